// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands one multiplier bit per clock, using a single operand-wide adder. A caller presents the multiplicand and the multiplier and pulses `start` for one cycle while the unit is idle. The unit then runs for exactly `WIDTH` steps with `busy` high, and raises `done` for a single cycle once the full double-width product is ready on `prod_hi` and `prod_lo`.

Internally the multiplier operand is parked in the lower half of one double-width accumulation register whose upper half starts at zero. On each step the least significant bit of that register decides whether the multiplicand is added into the upper half. The whole register then moves right by one position, and the adder's carry-out enters at the top. After the last step the register holds the product. Its low half is also the truncated single-width product.

Top module: `shift_add_mul`

## Requirements
- R1: After `done`, `{prod_hi, prod_lo}` equals the full unsigned product of the multiplicand and multiplier that were captured when `start` was accepted, with `2*WIDTH` bits, for any operand values including zero.
- R2: `done` is high exactly `WIDTH` clock edges after the edge at which `start` was accepted. `busy` is high from the edge after acceptance until that same edge.
- R3: `done` is a single-cycle pulse, and `busy` is low whenever `done` is high.
- R4: A `start` pulse that arrives while `busy` is high is ignored. The running product and its timing are unaffected, and the new operands are not used.
- R5: While the unit is idle and `start` is low, `prod_hi` and `prod_lo` stay unchanged from the last completed result.
- R6: The carry-out of every addition is kept. All-ones operands give `prod_hi` = all-ones minus one and `prod_lo` = 1.
- R7: After synchronous reset, `busy` and `done` are low and both result words are zero.
- R8: `prod_lo` equals the product taken modulo 2^`WIDTH`.
- R9: A `start` sampled in the same cycle as `done` is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply; accepted only while idle |
| mcand | input | WIDTH | Multiplicand, captured on an accepted start |
| mplier | input | WIDTH | Multiplier, captured on an accepted start |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_hi | output | WIDTH | Upper half of the product |
| prod_lo | output | WIDTH | Lower half of the product |

## Verification
The assertions assume that `start` and the operands are clean synchronous values sampled at rising edges, and that the caller reads the product only after `done`. The bench changes every input on the falling edge only. It keeps `start` high for a single cycle, except where it deliberately pulses `start` in mid-operation to test R4 or in the `done` cycle to test R9. The operands are fixed-seed random values mixed with zeros, ones, all-ones and single-bit patterns.

// File: rtl/mul_pkg.sv
package mul_pkg;

  // Per-cycle command from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture operands, clear upper half
    logic step;   // one conditional add plus right shift
  } mul_cmd_t;

endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] addend,
  input  logic             en,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH-1:0] gated;

  // A zero multiplier bit contributes nothing to the partial sum.
  always_comb begin
    gated = en ? addend : '0;
    {cout, sum} = {1'b0, acc} + {1'b0, gated};
  end

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  output mul_cmd_t cmd,
  output logic     busy,
  output logic     done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] step_cnt;
  logic          accept;

  assign accept   = start && !busy;
  assign cmd.load = accept;
  assign cmd.step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        step_cnt <= '0;
      end else if (busy) begin
        step_cnt <= step_cnt + 1'b1;
        if (step_cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: completion lasts exactly one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: completion never overlaps running steps
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: the run keeps going until the last step
  p_run_len_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && step_cnt != LAST) |=> busy);

  // R2: the last step ends the run and signals completion
  p_finish_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && step_cnt == LAST) |=> (!busy && done));

  // R4: a start during a run does not rewind the step counter
  p_no_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && start && step_cnt != LAST) |=> (step_cnt == $past(step_cnt) + 1'b1));

  // R9: start in the completion cycle begins a new run
  p_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (busy && step_cnt == '0));

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  mul_cmd_t           cmd,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] acc_q
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] sum;
  logic             cout;

  mul_adder #(.WIDTH(WIDTH)) u_adder (
    .acc    (acc_q[PW-1:WIDTH]),
    .addend (mcand_q),
    .en     (acc_q[0]),
    .sum    (sum),
    .cout   (cout)
  );

  // The upper half accumulates and the lower half holds the unconsumed
  // multiplier bits. The carry enters at the top as everything moves right.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (cmd.load) begin
      acc_q   <= {{WIDTH{1'b0}}, mplier_in};
      mcand_q <= mcand_in;
    end else if (cmd.step) begin
      acc_q   <= {cout, sum, acc_q[WIDTH-1:1]};
    end
  end

  // R1: a load starts from a clean upper half holding nothing but the multiplier
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> (acc_q[PW-1:WIDTH] == '0 && acc_q[WIDTH-1:0] == $past(mplier_in)));

  // R1: a zero multiplier bit just shifts the upper half down
  p_zero_bit_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd.step && !cmd.load && !acc_q[0]) |=>
      (acc_q[PW-1:WIDTH-1] == {1'b0, $past(acc_q[PW-1:WIDTH])}));

  // R5: with no command the result holds
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && !cmd.step) |=> $stable(acc_q));

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);

  localparam int PW = 2 * WIDTH;

  mul_cmd_t        cmd;
  logic [PW-1:0]   acc_q;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .cmd   (cmd),
    .busy  (busy),
    .done  (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .mcand_in  (mcand),
    .mplier_in (mplier),
    .acc_q     (acc_q)
  );

  assign prod_hi = acc_q[PW-1:WIDTH];
  assign prod_lo = acc_q[WIDTH-1:0];

  // R4: operands presented during a run never trigger a reload
  p_ignore_start_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |-> !cmd.load);

endmodule

// File: tb/test_shift_add_mul.sv
`timescale 1ns/1ps
module test_shift_add_mul;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shift_add_mul #(.WIDTH(W)) i_shift_add_mul (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  function automatic logic [2*W-1:0] full_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] xa = {{W{1'b0}}, a};
    logic [2*W-1:0] xb = {{W{1'b0}}, b};
    return xa * xb;
  endfunction

  function automatic logic [W-1:0] trunc_mul(logic [W-1:0] a, logic [W-1:0] b);
    return a * b;
  endfunction

  task automatic check(bit ok, string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Starts an operation at the current falling edge; optionally pulses start
  // again after inject_at cycles with other operands. Returns at the falling
  // edge where done is seen.
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, int inject_at,
                        logic [W-1:0] ia, logic [W-1:0] ib, bit hold_check);
    int n = 0;
    bit busy_ok = 1;
    logic [2*W-1:0] exp = full_mul(a, b);
    start = 1'b1; mcand = a; mplier = b;
    @(posedge clk);
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (done) break;
      n++;
      if (!busy) busy_ok = 0;
      if (n == inject_at) begin
        start = 1'b1; mcand = ia; mplier = ib;
      end
      if (n > 3 * W) break;
    end
    check(n == W && done, "R2 latency", 64'(n), 64'(W));
    check(busy_ok, "R2 busy during run", 64'(busy_ok), 64'd1);
    check(!busy, "R3 busy low with done", 64'(busy), 64'd0);
    check({prod_hi, prod_lo} == exp, inject_at >= 0 ? "R4 product" : "R1 product",
          {prod_hi, prod_lo}, exp);
    check(prod_lo == trunc_mul(a, b), "R8 low word", 64'(prod_lo), 64'(trunc_mul(a, b)));
    if (hold_check) begin
      mcand = ~a; mplier = ~b;
      @(negedge clk);
      check(!done, "R3 done one cycle", 64'(done), 64'd0);
      repeat (3) @(negedge clk);
      check({prod_hi, prod_lo} == exp, "R5 hold", {prod_hi, prod_lo}, exp);
    end
  endtask

  initial begin
    logic [W-1:0] ones = '1;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!busy && !done, "R7 reset flags", {62'd0, busy, done}, 64'd0);
    check(prod_hi == '0 && prod_lo == '0, "R7 reset product", {prod_hi, prod_lo}, 64'd0);

    run_op(ones, ones, -1, 0, 0, 1);
    check(prod_hi == ones - 1 && prod_lo == 1, "R6 carry kept",
          {prod_hi, prod_lo}, {ones - 32'd1, 32'd1});
    run_op(0, 0, -1, 0, 0, 1);
    run_op(ones, 0, -1, 0, 0, 1);
    run_op(0, ones, -1, 0, 0, 0);
    run_op(ones, 1, -1, 0, 0, 1);
    run_op(1, ones, -1, 0, 0, 0);
    run_op(32'h8000_0000, 32'h8000_0000, -1, 0, 0, 1);
    run_op(32'hAAAA_AAAA, 32'h5555_5555, -1, 0, 0, 0);
    // R4: mid-run start with different operands must be ignored
    run_op(32'd12345, 32'd678, 10, ones, ones, 1);
    run_op(32'hDEAD_BEEF, 32'h0000_0003, W - 1, 32'd7, 32'd9, 1);
    // R9: next start issued in the done cycle (no hold wait)
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a = $urandom();
      logic [W-1:0] b = $urandom();
      if (i % 7 == 0) b = b >> (i % W);
      run_op(a, b, (i % 5 == 0) ? int'($urandom_range(W - 1, 1)) : -1,
             $urandom(), $urandom(), (i % 4 == 0));
    end
    run_op(32'd3, 32'd5, -1, 0, 0, 0);
    run_op(32'd7, 32'd11, -1, 0, 0, 0);
    check({prod_hi, prod_lo} == 64'd77, "R9 back to back", {prod_hi, prod_lo}, 64'd77);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule